// File: doc/BRIEF.md
# Double-Buffered Timed Pattern Sequencer

This block plays a list of output states onto two 16-bit ports. The states sit in an external pattern memory that holds two banks of 4096 entries each. One bank is active and is being played, and the other is the preload bank that the host fills. Each entry carries a word for each port, a dwell count and an end marker. A programmable divider sets the tick rate. Each state is held for its dwell count of ticks, and the block then fetches the next entry through a combinational read port.

When the sequencer reaches the marked last entry, it does one of three things:
- If a stop is pending, it goes idle.
- If a switch is pending, it swaps the bank roles and plays the new pattern with no gap.
- Otherwise, it plays the same bank again from entry 0.

A switch can be held back until the next rising edge of a once-per-second timing pulse. That pulse input is synchronized inside the block. The host learns of each completed swap from a one-cycle notification.

Top module: `pattern_seq`

## Requirements
- R1: After reset the block is idle: `running` = 0, `waiting_pps` = 0, `active_bank` = 0, both ports are 0 and `mem_addr` = 0. Whenever the block is idle, both ports read 0.
- R2: The memory entry layout is as follows: bits [15:0] hold the port A word, [31:16] the port B word, [47:32] the dwell count H, and bit 48 the end marker. A `start` pulse while idle fetches entry 0 of the active bank. At the next clock edge, its words appear on the ports and `running` rises. A `start` while running has no effect.
- R3: With divider value D and dwell count H, a state stays on the ports for exactly (H+1)*(D+1) clock cycles.
- R4: A new `div_val` is taken only when a state is loaded. A change during a state does not alter that state's length, and it sets the length of the following states.
- R5: After an entry without the end marker, entry index+1 of the same bank follows. After the end entry with nothing pending, entry 0 of the same bank follows in the very next cycle.
- R6: A `stop_req` pulse while running is remembered, and playback goes on to the end of the pattern. At that boundary, the block goes idle and zeroes both ports.
- R7: With `pps_align` = 0, a remembered `switch_req` takes effect at the end boundary. `active_bank` flips, entry 0 of the other bank appears at that same edge, and `swap_done` is high for exactly that one cycle.
- R8: With `pps_align` = 1, a pending switch at the end boundary makes the block hold the last words on the ports with `waiting_pps` = 1. The swap commits on the third clock edge after `pps_in` rises (two synchronizer stages plus an edge detector). Entry 0 of the other bank then plays.
- R9: `active_bank` changes only together with `swap_done`. A stop leaves the bank unchanged, and the next start plays the bank that was last made active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin playback from entry 0 of the active bank |
| stop_req | input | 1 | Request to halt at the end of the pattern |
| switch_req | input | 1 | Request to swap banks at the end of the pattern |
| pps_in | input | 1 | Asynchronous once-per-second timing pulse |
| pps_align | input | 1 | 1: a bank swap waits for a rising edge of pps_in |
| div_val | input | 16 | Tick divider; one tick lasts div_val+1 cycles |
| mem_data | input | 49 | Pattern entry read at mem_addr |
| mem_addr | output | 13 | {bank, entry index} of the entry to load next |
| port_a | output | 16 | Output word A |
| port_b | output | 16 | Output word B |
| running | output | 1 | Playing or waiting for the timing pulse |
| waiting_pps | output | 1 | Held at pattern end awaiting the timing pulse |
| active_bank | output | 1 | Bank currently played |
| swap_done | output | 1 | One-cycle pulse when a bank swap commits |

## Verification
- **Start response:** A start shows entry 0 on the ports one edge after it is sampled, so the bench checks the first word at the falling edge that follows.
- **State lengths:** Every later state change is due (H+1)*(D+1) edges after the previous one. The bench counts falling edges from a known reference until the expected word appears, and compares that count with the product.
- **Stop and swap timing:** Stop and swap outcomes land on the end-boundary edge, so counts run across the whole pattern.
- **Aligned swap:** An aligned swap is due three edges after the timing pulse is raised at a falling edge. The bench counts exactly that span.

// File: rtl/pattern_seq.sv
module pattern_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int HOLD_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         stop_req,
  input  logic                         switch_req,
  input  logic                         pps_in,
  input  logic                         pps_align,
  input  logic [DIV_W-1:0]             div_val,
  input  logic [2*DATA_W+HOLD_W:0]     mem_data,
  output logic [ADDR_W:0]              mem_addr,
  output logic [DATA_W-1:0]            port_a,
  output logic [DATA_W-1:0]            port_b,
  output logic                         running,
  output logic                         waiting_pps,
  output logic                         active_bank,
  output logic                         swap_done
);

  localparam int HOLD_LSB = 2*DATA_W;
  localparam int LAST_BIT = 2*DATA_W + HOLD_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] idx;
  logic [HOLD_W-1:0] dwell;
  logic [DIV_W-1:0]  pre, div_lat;
  logic              last_q, stop_pend, sw_pend;
  logic [2:0]        pps_sh;

  logic              pps_edge, tick, boundary, at_end;
  logic              do_stop, do_wait, do_swap, load;
  logic              next_bank;
  logic [ADDR_W-1:0] next_idx;

  assign pps_edge = pps_sh[1] & ~pps_sh[2];
  assign tick     = (pre == '0);
  assign boundary = (st == S_RUN) && tick && (dwell == '0);
  assign at_end   = boundary && last_q;

  assign do_stop  = stop_pend && (at_end || st == S_WAIT);
  assign do_wait  = at_end && !stop_pend && sw_pend && pps_align;
  assign do_swap  = (at_end && !stop_pend && sw_pend && !pps_align) ||
                    (st == S_WAIT && !stop_pend && pps_edge);
  assign load     = (st == S_IDLE && start) ||
                    (boundary && !do_stop && !do_wait) ||
                    (st == S_WAIT && !stop_pend && pps_edge);

  assign next_bank = do_swap ? ~active_bank : active_bank;
  assign next_idx  = (st == S_RUN && !last_q) ? idx + 1'b1 : '0;
  assign mem_addr  = {next_bank, next_idx};

  assign running     = (st != S_IDLE);
  assign waiting_pps = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) pps_sh <= '0;
    else        pps_sh <= {pps_sh[1:0], pps_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:  if (start) st <= S_RUN;
        S_RUN:   if (do_stop) st <= S_IDLE;
                 else if (do_wait) st <= S_WAIT;
        S_WAIT:  if (do_stop) st <= S_IDLE;
                 else if (pps_edge) st <= S_RUN;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_pend <= 1'b0;
      sw_pend   <= 1'b0;
    end else begin
      if (do_stop || st == S_IDLE) stop_pend <= 1'b0;
      else if (stop_req)           stop_pend <= 1'b1;
      if (do_swap)                 sw_pend   <= 1'b0;
      else if (switch_req)         sw_pend   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_bank <= 1'b0;
      swap_done   <= 1'b0;
    end else begin
      active_bank <= next_bank;
      swap_done   <= do_swap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_a  <= '0;
      port_b  <= '0;
      idx     <= '0;
      dwell   <= '0;
      last_q  <= 1'b0;
      pre     <= '0;
      div_lat <= '0;
    end else if (load) begin
      port_a  <= mem_data[DATA_W-1:0];
      port_b  <= mem_data[2*DATA_W-1:DATA_W];
      dwell   <= mem_data[LAST_BIT-1:HOLD_LSB];
      last_q  <= mem_data[LAST_BIT];
      idx     <= next_idx;
      pre     <= div_val;
      div_lat <= div_val;
    end else if (do_stop) begin
      port_a  <= '0;
      port_b  <= '0;
    end else if (st == S_RUN) begin
      if (tick) begin
        pre <= div_lat;
        if (dwell != '0) dwell <= dwell - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pattern_seq_chk.sv
module pattern_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              running,
  input logic              waiting_pps,
  input logic              active_bank,
  input logic              swap_done,
  input logic [DATA_W-1:0] port_a,
  input logic [DATA_W-1:0] port_b
);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (port_a == '0 && port_b == '0));

  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start) |=> running);

  a_r7_swap_flips: assert property (@(posedge clk) disable iff (!rst_n)
    swap_done |-> (active_bank != $past(active_bank)));

  a_r8_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_pps && $past(waiting_pps)) |-> ($stable(port_a) && $stable(port_b)));

  a_r9_bank_only_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (active_bank != $past(active_bank)) |-> swap_done);

endmodule

bind pattern_seq pattern_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running),
  .waiting_pps(waiting_pps), .active_bank(active_bank), .swap_done(swap_done),
  .port_a(port_a), .port_b(port_b)
);

// File: tb/test_pattern_seq.sv
module test_pattern_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop_req = 1'b0, switch_req = 1'b0;
  logic        pps_in = 1'b0, pps_align = 1'b0;
  logic [15:0] div_val = '0;
  logic [48:0] mem_data;
  logic [12:0] mem_addr;
  logic [15:0] port_a, port_b;
  logic        running, waiting_pps, active_bank, swap_done;

  logic [48:0] mem [0:8191];
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign mem_data = mem[mem_addr];

  pattern_seq i_pattern_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
    .switch_req(switch_req), .pps_in(pps_in), .pps_align(pps_align),
    .div_val(div_val), .mem_data(mem_data), .mem_addr(mem_addr),
    .port_a(port_a), .port_b(port_b), .running(running),
    .waiting_pps(waiting_pps), .active_bank(active_bank), .swap_done(swap_done)
  );

  // rows: hold H, divider D, expected cycles (H+1)*(D+1)
  localparam int TBL [6][3] = '{'{0,0,1}, '{1,0,2}, '{3,0,4}, '{0,2,3}, '{2,1,6}, '{4,3,20}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit b, input int i, input logic [15:0] a, input logic [15:0] pb,
                     input logic [15:0] h, input bit e);
    mem[{b, 12'(i)}] = {e, h, pb, a};
  endtask

  task automatic until_word(input logic [15:0] w, output int n);
    n = 0;
    while (port_a != w && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic halt();
    int n = 0;
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    while (running && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pattern_a();
    put(0, 0, 16'h1111, 16'h5555, 16'd1, 1'b0);
    put(0, 1, 16'h2222, 16'h6666, 16'd0, 1'b0);
    put(0, 2, 16'h3333, 16'h7777, 16'd2, 1'b1);
  endtask

  initial begin
    int n;
    for (int i = 0; i < 8192; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!running && !waiting_pps && !active_bank, "R1 status", {running, waiting_pps, active_bank}, 0);
    check(port_a == 0 && port_b == 0, "R1 ports", port_a, 0);
    check(mem_addr == 0, "R1 addr", mem_addr, 0);

    // R2/R3 table of dwell and divider combinations
    for (int r = 0; r < 6; r++) begin
      put(0, 0, 16'h0A00 + 16'(r), 16'hC0DE, 16'(TBL[r][0]), 1'b0);
      put(0, 1, 16'h0B00 + 16'(r), 16'h0000, 16'd0, 1'b1);
      div_val = 16'(TBL[r][1]);
      kick();
      check(port_a == 16'h0A00 + 16'(r) && port_b == 16'hC0DE && running, "R2 first entry", port_a, 16'h0A00 + r);
      until_word(16'h0B00 + 16'(r), n);
      check(n == TBL[r][2], "R3 dwell length", n, TBL[r][2]);
      halt();
    end
    div_val = 0;
    pattern_a();

    // R5 advance then restart at entry 0
    kick();
    until_word(16'h3333, n);
    check(n == 3, "R5 advance", n, 3);
    until_word(16'h1111, n);
    check(n == 3 && running, "R5 repeat", n, 3);
    // R2 start while running ignored
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(port_a == 16'h2222, "R2 start ignored", port_a, 16'h2222);
    halt();

    // R4 divider change mid-state
    kick();
    div_val = 16'd4;
    until_word(16'h2222, n);
    check(n == 2, "R4 current state unchanged", n, 2);
    until_word(16'h3333, n);
    check(n == 5, "R4 next state uses new divider", n, 5);
    div_val = 0;
    halt();

    // R6 stop waits for pattern end
    kick();
    stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    check(running == 1'b1, "R6 still running", running, 1);
    n = 1;
    while (running && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(n == 6, "R6 stop at end", n, 6);
    check(port_a == 0 && port_b == 0, "R6 ports zero", port_a, 0);
    repeat (4) @(negedge clk);
    check(!running && active_bank == 0, "R9 stop keeps bank", active_bank, 0);

    // R7 unaligned switch
    put(1, 0, 16'hC000, 16'h0001, 16'd0, 1'b0);
    put(1, 1, 16'hC001, 16'h0002, 16'd0, 1'b1);
    kick();
    switch_req = 1'b1;
    @(negedge clk) switch_req = 1'b0;
    n = 1;
    while (port_a != 16'hC000 && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(n == 6, "R7 swap at end", n, 6);
    check(active_bank == 1 && swap_done == 1, "R7 bank and notice", {active_bank, swap_done}, 3);
    @(negedge clk);
    check(swap_done == 0 && port_a == 16'hC001, "R7 notice one cycle", {swap_done, port_a}, 16'hC001);
    until_word(16'hC000, n);
    check(n == 1, "R5 new bank repeats", n, 1);
    halt();
    check(active_bank == 1, "R9 bank kept after stop", active_bank, 1);

    // R2 start plays last active bank; R8 aligned switch
    pps_align = 1'b1;
    kick();
    check(port_a == 16'hC000, "R2 start on bank 1", port_a, 16'hC000);
    switch_req = 1'b1;
    @(negedge clk) switch_req = 1'b0;
    repeat (8) @(negedge clk);
    check(waiting_pps && running && port_a == 16'hC001 && active_bank == 1, "R8 hold while waiting", port_a, 16'hC001);
    pps_in = 1'b1;
    until_word(16'h1111, n);
    check(n == 3, "R8 commit on pulse", n, 3);
    check(active_bank == 0 && !waiting_pps, "R8 bank after pulse", active_bank, 0);
    pps_in = 1'b0;
    halt();
    check(!running && port_a == 0, "R1 idle zero", port_a, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule